// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a 32-bit register datapath and a data memory that is addressed by byte but read and written one 32-bit word at a time. For a load, it takes the byte address, the access size and the word read from memory. It returns the addressed byte, halfword or word as a 32-bit result. Byte and halfword results are zero-extended.

For a store, it copies the low byte or low halfword of the source register into every lane of the write word. It then produces a 4-bit byte-enable mask, and only that mask decides which bytes memory actually takes.

Lanes follow big-endian order: the byte at the lowest address of a word is its most significant byte. Halfword and word accesses are checked for alignment. When an access is misaligned, a fault flag rises in the same cycle, the enables are held low and the load result is zero.

The unit is purely combinational. It holds no state, so it can be placed in whichever pipeline stage computes the effective address.

Top module: `be_lane_unit`

## Requirements
- R1: A byte access (size code 2'b00) at byte offset k = addr[1:0] returns `rd_word[31-8k -: 8]` in `ld_result[7:0]`, with `ld_result[31:8]` zero. For example, a word holding 0x00000005 gives 0x05 at offset 3 and 0x00 at offset 0.
- R2: A halfword access (size code 2'b01) returns `rd_word[31:16]` at offset 0 and `rd_word[15:0]` at offset 2, zero-extended to 32 bits.
- R3: A word access (size code 2'b10) at offset 0 returns `rd_word` unchanged.
- R4: `wr_word` holds the low byte of `st_data` repeated in all four lanes for a byte access. It holds the low halfword repeated twice for a halfword access, and `st_data` itself for a word access or size code 2'b11. This holds whether or not a write is requested.
- R5: When a store is requested and aligned, `wr_be[3]` enables offset 0 and `wr_be[0]` enables offset 3.
  - A byte store enables only the bit for its offset.
  - A halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2.
  - A word store enables 4'b1111.
- R6: `misalign` is high for a halfword access at an odd offset, for a word access at any nonzero offset, and for the reserved size code 2'b11. It is never high for a byte access.
- R7: While `misalign` is high, `wr_be` is 4'b0000 and `ld_result` is zero, whatever `wr_req` is.
- R8: With `wr_req` low, `wr_be` is 4'b0000, while `ld_result` still carries the load value.
- R9: Address bits above bit 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_req | input | 1 | High for a store |
| rd_word | input | 32 | Word read from memory at the containing word address |
| st_data | input | 32 | Source register value for a store |
| ld_result | output | 32 | Zero-extended load value |
| wr_word | output | 32 | Write word with store data replicated across lanes |
| wr_be | output | 4 | Byte enables, bit 3 = offset 0 |
| misalign | output | 1 | Alignment fault for the current access |

## Verification
The hardest case to reach is an access that is a store and misaligned at once. In that case the fault must win over `wr_req`, and the replicated write word must still appear on `wr_word` while every enable stays low. The vector table therefore mixes aligned and misaligned stores of each size with the reserved size code.

A directed sweep then walks every offset with every size code, with the store request both low and high, each time under several upper address patterns. The result of each combination is compared with a model written from the lane rules.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
  import be_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  acc_size_e        size,
  output logic             fault
);

  always_comb begin
    unique case (size)
      SZ_BYTE: fault = 1'b0;
      SZ_HALF: fault = off[0];
      SZ_WORD: fault = |off;
      default: fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 2
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic              fault,
  output logic [DATA_W-1:0] ld_result
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int HALVES = LANES / 2;

  logic [BYTE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;

  // lane i (bit position) holds address offset LANES-1-i
  always_comb begin
    byte_pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (int'(off) == LANES - 1 - i) begin
        byte_pick = rd_word[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    half_pick = '0;
    for (int j = 0; j < HALVES; j++) begin
      if (int'(off >> 1) == HALVES - 1 - j) begin
        half_pick = rd_word[j*HALF_W +: HALF_W];
      end
    end
  end

  always_comb begin
    ld_result = '0;
    if (!fault) begin
      unique case (size)
        SZ_BYTE: ld_result = {{(DATA_W-BYTE_W){1'b0}}, byte_pick};
        SZ_HALF: ld_result = {{(DATA_W-HALF_W){1'b0}}, half_pick};
        SZ_WORD: ld_result = rd_word;
        default: ld_result = '0;
      endcase
    end
  end

endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import be_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 2
) (
  input  logic [DATA_W-1:0]        st_data,
  input  logic [OFF_W-1:0]         off,
  input  acc_size_e                size,
  input  logic                     wr_en,
  input  logic                     fault,
  output logic [DATA_W-1:0]        wr_word,
  output logic [DATA_W/BYTE_W-1:0] wr_be
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int HALVES = LANES / 2;

  logic [LANES-1:0] be_raw;

  always_comb begin
    unique case (size)
      SZ_BYTE: wr_word = {LANES{st_data[BYTE_W-1:0]}};
      SZ_HALF: wr_word = {HALVES{st_data[HALF_W-1:0]}};
      default: wr_word = st_data;
    endcase
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane_be
      always_comb begin
        unique case (size)
          SZ_BYTE: be_raw[i] = (int'(off) == LANES - 1 - i);
          SZ_HALF: be_raw[i] = (int'(off >> 1) == HALVES - 1 - i / 2);
          SZ_WORD: be_raw[i] = 1'b1;
          default: be_raw[i] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign wr_be = (wr_en && !fault) ? be_raw : '0;

endmodule

// File: rtl/be_lane_unit.sv
module be_lane_unit
  import be_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               acc_size,
  input  logic                     wr_req,
  input  logic [DATA_W-1:0]        rd_word,
  input  logic [DATA_W-1:0]        st_data,
  output logic [DATA_W-1:0]        ld_result,
  output logic [DATA_W-1:0]        wr_word,
  output logic [DATA_W/BYTE_W-1:0] wr_be,
  output logic                     misalign
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W-1:0] off;
  acc_size_e        size;
  logic             unused_addr_hi;

  assign off            = addr[OFF_W-1:0];
  assign size           = acc_size_e'(acc_size);
  assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W];

  lane_align_chk #(.OFF_W(OFF_W)) i_align (
    .off   (off),
    .size  (size),
    .fault (misalign)
  );

  lane_load_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W)) i_load (
    .rd_word   (rd_word),
    .off       (off),
    .size      (size),
    .fault     (misalign),
    .ld_result (ld_result)
  );

  lane_store_steer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W)) i_store (
    .st_data (st_data),
    .off     (off),
    .size    (size),
    .wr_en   (wr_req),
    .fault   (misalign),
    .wr_word (wr_word),
    .wr_be   (wr_be)
  );

endmodule

// File: rtl/be_lane_unit_chk.sv
module be_lane_unit_chk (
  input logic [31:0] addr,
  input logic [1:0]  acc_size,
  input logic        wr_req,
  input logic [31:0] ld_result,
  input logic [31:0] wr_word,
  input logic [3:0]  wr_be,
  input logic        misalign
);

  logic known;
  assign known = !$isunknown({addr, acc_size, wr_req});

  always_comb begin
    if (known) begin
      assert_byte_never_faults_R6: assert (!(acc_size == 2'b00 && misalign))
        else $error("byte access flagged misaligned");
      assert_fault_clears_R7: assert (!misalign || (wr_be == 4'b0000 && ld_result == 32'h0))
        else $error("fault did not clear enables/result");
      assert_no_write_without_req_R8: assert (wr_req || wr_be == 4'b0000)
        else $error("enable without store request");
      assert_byte_zero_ext_R1: assert (acc_size != 2'b00 || ld_result[31:8] == 24'h0)
        else $error("byte load not zero-extended");
      assert_half_zero_ext_R2: assert (acc_size != 2'b01 || ld_result[31:16] == 16'h0)
        else $error("halfword load not zero-extended");
      assert_be_count_R5: assert (wr_be == 4'b0000 ||
                                  (acc_size == 2'b00 && $countones(wr_be) == 1) ||
                                  (acc_size == 2'b01 && $countones(wr_be) == 2) ||
                                  (acc_size == 2'b10 && wr_be == 4'b1111))
        else $error("enable mask does not match size");
      assert_byte_replicated_R4: assert (acc_size != 2'b00 ||
                                         (wr_word[31:24] == wr_word[7:0] &&
                                          wr_word[23:16] == wr_word[7:0] &&
                                          wr_word[15:8]  == wr_word[7:0]))
        else $error("byte store not replicated");
    end
  end

endmodule

bind be_lane_unit be_lane_unit_chk i_chk (
  .addr      (addr),
  .acc_size  (acc_size),
  .wr_req    (wr_req),
  .ld_result (ld_result),
  .wr_word   (wr_word),
  .wr_be     (wr_be),
  .misalign  (misalign)
);

// File: tb/test_be_lane_unit.sv
`timescale 1ns/1ps
module test_be_lane_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] addr;
  logic [1:0]  acc_size;
  logic        wr_req;
  logic [31:0] rd_word;
  logic [31:0] st_data;
  logic [31:0] ld_result;
  logic [31:0] wr_word;
  logic [3:0]  wr_be;
  logic        misalign;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  be_lane_unit i_be_lane_unit (
    .addr      (addr),
    .acc_size  (acc_size),
    .wr_req    (wr_req),
    .rd_word   (rd_word),
    .st_data   (st_data),
    .ld_result (ld_result),
    .wr_word   (wr_word),
    .wr_be     (wr_be),
    .misalign  (misalign)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        wr;
    logic [31:0] rd;
    logic [31:0] st;
    logic [31:0] e_ld;
    logic [31:0] e_wd;
    logic [3:0]  e_be;
    logic        e_f;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h100,      2'b00, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h01,       32'hD4D4D4D4, 4'b0000, 1'b0}, // R1 R8
    '{32'h103,      2'b00, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h67,       32'hD4D4D4D4, 4'b0000, 1'b0}, // R1
    '{32'h101,      2'b00, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h23,       32'hD4D4D4D4, 4'b0000, 1'b0}, // R1
    '{32'h102,      2'b01, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h4567,     32'hC3D4C3D4, 4'b0000, 1'b0}, // R2
    '{32'h100,      2'b01, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h0123,     32'hC3D4C3D4, 4'b0000, 1'b0}, // R2
    '{32'h101,      2'b01, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h0,        32'hC3D4C3D4, 4'b0000, 1'b1}, // R6 R7
    '{32'h100,      2'b10, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h01234567, 32'hA1B2C3D4, 4'b0000, 1'b0}, // R3
    '{32'h102,      2'b10, 1'b0, 32'h01234567, 32'hA1B2C3D4, 32'h0,        32'hA1B2C3D4, 4'b0000, 1'b1}, // R6 R7
    '{32'h102,      2'b00, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h45,       32'hD4D4D4D4, 4'b0010, 1'b0}, // R4 R5
    '{32'h102,      2'b01, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h4567,     32'hC3D4C3D4, 4'b0011, 1'b0}, // R4 R5
    '{32'h100,      2'b01, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h0123,     32'hC3D4C3D4, 4'b1100, 1'b0}, // R5
    '{32'h7FFC,     2'b10, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h01234567, 32'hA1B2C3D4, 4'b1111, 1'b0}, // R5 R9
    '{32'h103,      2'b10, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h0,        32'hA1B2C3D4, 4'b0000, 1'b1}, // R7
    '{32'h0,        2'b11, 1'b1, 32'h01234567, 32'hA1B2C3D4, 32'h0,        32'hA1B2C3D4, 4'b0000, 1'b1}, // R6 R4
    '{32'hFFFFFFF3, 2'b00, 1'b0, 32'h00000005, 32'h0,        32'h05,       32'h0,        4'b0000, 1'b0}, // R1 R9
    '{32'h10,       2'b00, 1'b0, 32'h00000005, 32'h0,        32'h00,       32'h0,        4'b0000, 1'b0}, // R1
    '{32'h0,        2'b00, 1'b1, 32'h01234567, 32'h000000EE, 32'h01,       32'hEEEEEEEE, 4'b1000, 1'b0}  // R5
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic [31:0] rd, input logic [31:0] st);
    @(negedge clk);
    addr = a; acc_size = sz; wr_req = wr; rd_word = rd; st_data = st;
    #1;
  endtask

  // model written from the requirement text
  task automatic model(input logic [1:0] off, input logic [1:0] sz, input logic wr,
                       input logic [31:0] rd, input logic [31:0] st,
                       output logic [31:0] e_ld, output logic [31:0] e_wd,
                       output logic [3:0] e_be, output logic e_f);
    e_f  = (sz == 2'b11) || (sz == 2'b01 && off[0]) || (sz == 2'b10 && off != 2'b00);
    e_ld = 32'h0;
    e_be = 4'b0000;
    case (sz)
      2'b00: e_wd = {4{st[7:0]}};
      2'b01: e_wd = {2{st[15:0]}};
      default: e_wd = st;
    endcase
    if (!e_f) begin
      case (sz)
        2'b00: begin e_ld = {24'h0, rd[31-8*off -: 8]}; e_be = 4'b1000 >> off; end
        2'b01: begin e_ld = (off == 2'b00) ? {16'h0, rd[31:16]} : {16'h0, rd[15:0]};
                     e_be = (off == 2'b00) ? 4'b1100 : 4'b0011; end
        default: begin e_ld = rd; e_be = 4'b1111; end
      endcase
      if (!wr) e_be = 4'b0000;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_ld, e_wd;
    logic [3:0]  e_be;
    logic        e_f;
    logic [31:0] hi_pat [3];
    hi_pat[0] = 32'h00000000; hi_pat[1] = 32'hFFFFFFFC; hi_pat[2] = 32'h5A5A5A58;

    rst_n = 1'b0;
    addr = '0; acc_size = '0; wr_req = 1'b0; rd_word = '0; st_data = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle state after reset with all-zero inputs
    apply(32'h0, 2'b00, 1'b0, 32'h0, 32'h0);
    check("R8", "idle wr_be", {28'h0, wr_be}, 32'h0);
    check("R6", "idle misalign", {31'h0, misalign}, 32'h0);
    check("R1", "idle ld_result", ld_result, 32'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].a, VECS[v].sz, VECS[v].wr, VECS[v].rd, VECS[v].st);
      check($sformatf("R1-vec%0d", v), "ld_result", ld_result, VECS[v].e_ld);
      check($sformatf("R4-vec%0d", v), "wr_word", wr_word, VECS[v].e_wd);
      check($sformatf("R5-vec%0d", v), "wr_be", {28'h0, wr_be}, {28'h0, VECS[v].e_be});
      check($sformatf("R6-vec%0d", v), "misalign", {31'h0, misalign}, {31'h0, VECS[v].e_f});
    end

    // directed sweep: all offsets, sizes, store request, upper address bits (R9)
    for (int h = 0; h < 3; h++) begin
      for (int s = 0; s < 4; s++) begin
        for (int o = 0; o < 4; o++) begin
          for (int w = 0; w < 2; w++) begin
            model(2'(o), 2'(s), 1'(w), 32'h8899AABB, 32'h13579BDF, e_ld, e_wd, e_be, e_f);
            apply(hi_pat[h] | 32'(o), 2'(s), 1'(w), 32'h8899AABB, 32'h13579BDF);
            check("R9 sweep R2 R3", "ld_result", ld_result, e_ld);
            check("R9 sweep R4", "wr_word", wr_word, e_wd);
            check("R9 sweep R5 R7 R8", "wr_be", {28'h0, wr_be}, {28'h0, e_be});
            check("R9 sweep R6", "misalign", {31'h0, misalign}, {31'h0, e_f});
          end
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule